// File: doc/BRIEF.md
# Two-Phase Lockable Watchdog Timer

This block is a watchdog for a chip-level system. Software loads a reload value, sets the count enable, and must refresh the watchdog regularly by writing a refresh register. Every refresh reloads the down-counter.

If software misses a deadline, the counter reaches zero and the block raises an interrupt. It then starts a second countdown from the same reload value. If that second countdown also runs out while the interrupt is still pending and reset escalation is enabled, the block pulses a system reset output for one cycle. After that pulse it returns itself to its power-on defaults.

Every register except the lock register is write-protected. Writes to them take effect only after the unlock key has been written to the lock register. The bus is a simple single-cycle register port. Reads are combinational from the addressed register, and a write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high.

Top module: `wdog_escalate`

## Requirements
- R1: After reset the block is locked, the reload value is LOAD_INIT (0x0000FFFF by default), the control register reads 0, and neither `wdt_irq` nor `wdt_sys_rst` is asserted.
- R2: Writing 0x1ACCE551 to the lock register (offset 4) unlocks the block, and the lock register then reads 0. Writing any other value to it locks the block, and it then reads 1.
- R3: While the block is locked, writes to the reload (offset 0), control (offset 2) and refresh (offset 3) registers change nothing.
- R4: A write to the reload register stores the value and loads it into the counter in the same edge. The current count reads back at offset 1.
- R5: The counter decrements by one per clock only while control bit 0 (count enable) is set. While that bit is clear, the count holds.
- R6: With count enable set, one cycle spent at zero is an expiry. The first expiry sets the pending interrupt on `wdt_irq` and reloads the counter. With reload value L, this happens L+1 edges after the edge that sets count enable.
- R7: A write to the refresh register reloads the counter and clears the pending interrupt. Reading offset 3 returns the pending interrupt in bit 0.
- R8: An expiry while the interrupt is still pending, with control bit 1 (reset enable) set, drives `wdt_sys_rst` high for exactly one cycle.
- R9: An expiry while the interrupt is still pending, with reset enable clear, produces no reset pulse. The interrupt stays pending and the counter reloads.
- R10: On the edge after the reset pulse, every register returns to its reset value, including the lock.
- R11: Refreshing more often than the expiry period keeps the interrupt deasserted indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| wdt_irq | output | 1 | First-phase timeout interrupt (level, pending) |
| wdt_sys_rst | output | 1 | Second-phase system reset pulse |

## Verification
A write is visible on a read at the falling edge that follows its write edge. The count moves once per rising edge, so the bench expects the count to be L−k after k edges counted from the write that sets count enable. The bench expects the interrupt after L+1 such edges, the reset pulse after 2L+2 edges, and the default state on the edge after that. All outputs are sampled at falling edges, and the bench counts the exact number of falling edges it waits from the completion of the enabling write. Timed tests start only after their last write, so setup writes cannot shift the window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W = 3;

    // Register word offsets
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_KICK  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LOCK  = 3'd4;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

    // Accepted write actions after lock filtering
    typedef struct packed {
        logic load;
        logic ctrl;
        logic kick;
    } wr_strobe_t;

endpackage

// File: rtl/wdog_gate.sv
module wdog_gate
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              locked_o,
    output wr_strobe_t        stb_o
);

    logic locked_d, locked_q;
    logic wr_hit;

    always_comb begin
        wr_hit   = bus_sel && bus_wr;
        locked_d = locked_q;
        if (wr_hit && bus_addr == A_LOCK) begin
            locked_d = (bus_wdata != DATA_W'(UNLOCK_KEY));
        end
        if (soft_rst) begin
            locked_d = 1'b1;
        end
        stb_o.load = wr_hit && !locked_q && bus_addr == A_LOAD;
        stb_o.ctrl = wr_hit && !locked_q && bus_addr == A_CTRL;
        stb_o.kick = wr_hit && !locked_q && bus_addr == A_KICK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
        end else begin
            locked_q <= locked_d;
        end
    end

    assign locked_o = locked_q;

    // R2: the key opens the gate on the next cycle
    p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_LOCK && !soft_rst &&
         bus_wdata == DATA_W'(UNLOCK_KEY)) |=> !locked_o);

    // R2: any other value closes it
    p_other_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_LOCK &&
         bus_wdata != DATA_W'(UNLOCK_KEY)) |=> locked_o);

    // R10: self reset re-locks
    p_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> locked_o);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               CNT_W     = 32,
    parameter logic [CNT_W-1:0] LOAD_INIT = CNT_W'(32'h0000_FFFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_en_o,
    output logic              rst_en_o,
    output logic              pend_o,
    output logic              sys_rst_o
);

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        logic             irq_en;
        logic             rst_en;
        logic             pend;
        logic             rst;
    } cnt_state_t;

    localparam cnt_state_t DEFAULTS = '{
        load:   LOAD_INIT,
        cnt:    LOAD_INIT,
        irq_en: 1'b0,
        rst_en: 1'b0,
        pend:   1'b0,
        rst:    1'b0
    };

    cnt_state_t st_d, st_q;
    logic       at_zero;

    always_comb begin
        st_d     = st_q;
        st_d.rst = 1'b0;
        at_zero  = (st_q.cnt == '0);
        if (st_q.rst) begin
            st_d = DEFAULTS;
        end else begin
            if (stb.ctrl) begin
                st_d.irq_en = wdata[0];
                st_d.rst_en = wdata[1];
            end
            if (stb.load) begin
                st_d.load = wdata[CNT_W-1:0];
                st_d.cnt  = wdata[CNT_W-1:0];
            end else if (stb.kick) begin
                st_d.cnt  = st_q.load;
                st_d.pend = 1'b0;
            end else if (st_q.irq_en) begin
                if (at_zero) begin
                    st_d.cnt = st_q.load;
                    if (!st_q.pend) begin
                        st_d.pend = 1'b1;
                    end else if (st_q.rst_en) begin
                        st_d.rst = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DEFAULTS;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o    = st_q.load;
    assign cnt_o     = st_q.cnt;
    assign irq_en_o  = st_q.irq_en;
    assign rst_en_o  = st_q.rst_en;
    assign pend_o    = st_q.pend;
    assign sys_rst_o = st_q.rst;

    // R8: reset pulse lasts one cycle
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |=> !st_q.rst);

    // R8: pulse only from a pending second expiry with escalation on
    p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rst) |-> $past(st_q.pend && st_q.rst_en && st_q.irq_en && st_q.cnt == '0));

    // R10: defaults follow the pulse
    p_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |=> (st_q.cnt == LOAD_INIT && st_q.load == LOAD_INIT &&
                      !st_q.pend && !st_q.irq_en && !st_q.rst_en));

    // R6: interrupt rises only from an enabled zero count
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(st_q.irq_en && st_q.cnt == '0));

    // R5: count holds while disabled and not reloaded
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.irq_en && !stb.load && !stb.kick && !st_q.rst) |=> $stable(st_q.cnt));

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wdog_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               CNT_W     = 32,
    parameter logic [CNT_W-1:0] LOAD_INIT = CNT_W'(32'h0000_FFFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_sys_rst
);

    wr_strobe_t       stb;
    logic             locked;
    logic [CNT_W-1:0] load_w, cnt_w;
    logic             irq_en_w, rst_en_w, pend_w, sys_rst_w;

    wdog_gate #(.DATA_W(DATA_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (sys_rst_w),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .locked_o  (locked),
        .stb_o     (stb)
    );

    wdog_count #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .LOAD_INIT (LOAD_INIT)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (stb),
        .wdata     (bus_wdata),
        .load_o    (load_w),
        .cnt_o     (cnt_w),
        .irq_en_o  (irq_en_w),
        .rst_en_o  (rst_en_w),
        .pend_o    (pend_w),
        .sys_rst_o (sys_rst_w)
    );

    always_comb begin
        case (bus_addr)
            A_LOAD:  bus_rdata = DATA_W'(load_w);
            A_COUNT: bus_rdata = DATA_W'(cnt_w);
            A_CTRL:  bus_rdata = DATA_W'({rst_en_w, irq_en_w});
            A_KICK:  bus_rdata = DATA_W'(pend_w);
            A_LOCK:  bus_rdata = DATA_W'(locked);
            default: bus_rdata = '0;
        endcase
    end

    assign wdt_irq     = pend_w;
    assign wdt_sys_rst = sys_rst_w;

    // R3: locked writes leave the configuration and the pending interrupt alone
    p_locked_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && locked && bus_addr != A_LOCK && !sys_rst_w)
        |=> ($stable(load_w) && $stable(irq_en_w) && $stable(rst_en_w) && !$fell(pend_w)));

    // R7: a refresh clears the interrupt
    p_kick_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !locked && bus_addr == A_KICK) |=> !wdt_irq);

endmodule

// File: tb/wdog_escalate_tb.sv
module wdog_escalate_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] KEY = 32'h1ACC_E551;
    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq, wdt_sys_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_escalate u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_irq     (wdt_irq),
        .wdt_sys_rst (wdt_sys_rst)
    );

    // {wr, addr, data, expected read, requirement number}
    localparam logic [71:0] VECS [0:NV-1] = '{
        {1'b0, 3'd4, 32'h0,        32'h1,        4'd1},  // R1 locked at reset
        {1'b0, 3'd2, 32'h0,        32'h0,        4'd1},  // R1 control clear
        {1'b1, 3'd0, 32'h33,       32'h0,        4'd3},  // R3 locked write
        {1'b0, 3'd0, 32'h0,        32'h0000FFFF, 4'd3},  // R3 reload unchanged
        {1'b1, 3'd4, KEY,          32'h0,        4'd2},  // R2 unlock
        {1'b0, 3'd4, 32'h0,        32'h0,        4'd2},  // R2 reads unlocked
        {1'b1, 3'd0, 32'h33,       32'h0,        4'd4},  // R4 reload write
        {1'b0, 3'd0, 32'h0,        32'h33,       4'd4},  // R4 reload stored
        {1'b0, 3'd1, 32'h0,        32'h33,       4'd4},  // R4 counter loaded
        {1'b1, 3'd2, 32'h2,        32'h0,        4'd5},  // R5 escalation only
        {1'b0, 3'd2, 32'h0,        32'h2,        4'd5},  // R5 control readback
        {1'b0, 3'd1, 32'h0,        32'h33,       4'd5},  // R5 count held
        {1'b1, 3'd4, 32'h1234,     32'h0,        4'd2},  // R2 wrong key locks
        {1'b0, 3'd4, 32'h0,        32'h1,        4'd2},  // R2 reads locked
        {1'b1, 3'd2, 32'h0,        32'h0,        4'd3},  // R3 locked ctrl write
        {1'b0, 3'd2, 32'h0,        32'h2,        4'd3},  // R3 control unchanged
        {1'b1, 3'd4, KEY,          32'h0,        4'd2}   // R2 unlock again
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1);
        chk("R1 irq", {31'b0, wdt_irq}, 32'h0);
        chk("R1 sys_rst", {31'b0, wdt_sys_rst}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][71]) begin
                bus_write(VECS[i][70:68], VECS[i][67:36]);
            end else begin
                bus_read(VECS[i][70:68], rd);
                n_chk++;
                if (rd !== VECS[i][35:4]) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h",
                             VECS[i][3:0], i, rd, VECS[i][35:4]);
                end
            end
        end

        // Phase A: interrupt then reset (R4 R5 R6 R7 R8 R10)
        bus_write(3'd0, 32'd5);
        bus_read(3'd1, rd);  chk("R4 count after reload", rd, 32'd5);
        bus_write(3'd2, 32'h3);
        bus_read(3'd1, rd);  chk("R5 no move on enable edge", rd, 32'd5);
        step(1);
        bus_read(3'd1, rd);  chk("R5 decrement", rd, 32'd4);
        step(4);
        bus_read(3'd1, rd);  chk("R5 at zero", rd, 32'd0);
        chk("R6 no irq before expiry", {31'b0, wdt_irq}, 32'h0);
        step(1);
        chk("R6 irq on first expiry", {31'b0, wdt_irq}, 32'h1);
        bus_read(3'd1, rd);  chk("R6 reload on expiry", rd, 32'd5);
        bus_read(3'd3, rd);  chk("R7 pending readback", rd, 32'h1);
        step(5);
        chk("R8 no reset early", {31'b0, wdt_sys_rst}, 32'h0);
        step(1);
        chk("R8 reset on second expiry", {31'b0, wdt_sys_rst}, 32'h1);
        step(1);
        chk("R8 reset one cycle", {31'b0, wdt_sys_rst}, 32'h0);
        chk("R10 irq cleared", {31'b0, wdt_irq}, 32'h0);
        bus_read(3'd4, rd);  chk("R10 relocked", rd, 32'h1);
        bus_read(3'd0, rd);  chk("R10 reload default", rd, 32'h0000FFFF);
        bus_read(3'd2, rd);  chk("R10 control default", rd, 32'h0);

        // Phase B: no escalation without reset enable (R9 R7)
        bus_write(3'd4, KEY);
        bus_write(3'd0, 32'd3);
        bus_write(3'd2, 32'h1);
        step(4);
        chk("R6 irq after L+1", {31'b0, wdt_irq}, 32'h1);
        step(4);
        chk("R9 no reset", {31'b0, wdt_sys_rst}, 32'h0);
        chk("R9 irq still pending", {31'b0, wdt_irq}, 32'h1);
        bus_read(3'd1, rd);  chk("R9 reload on second expiry", rd, 32'd3);
        bus_write(3'd3, 32'h0);
        chk("R7 refresh clears irq", {31'b0, wdt_irq}, 32'h0);
        bus_read(3'd1, rd);  chk("R7 refresh reloads", rd, 32'd3);

        // Phase C: frequent refresh (R11)
        for (int k = 0; k < 6; k++) begin
            step(1);
            bus_write(3'd3, 32'h0);
        end
        chk("R11 irq stays low", {31'b0, wdt_irq}, 32'h0);

        // Phase D: locked refresh ignored while pending (R3)
        step(4);
        chk("R6 irq before locked refresh", {31'b0, wdt_irq}, 32'h1);
        bus_write(3'd4, 32'h0);
        bus_write(3'd3, 32'h0);
        chk("R3 locked refresh ignored", {31'b0, wdt_irq}, 32'h1);

        // Phase E: stop holds count (R5)
        bus_write(3'd4, KEY);
        bus_write(3'd2, 32'h0);
        bus_read(3'd1, c1);
        step(5);
        bus_read(3'd1, rd);  chk("R5 count held when disabled", rd, c1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule